// File: doc/BRIEF.md
# Uncorrectable Error Header Logger

This block sits beside the error reporting logic of a serial link port. It keeps the uncorrectable error status bits, captures the header of the packet that caused the first header-saving uncorrectable error, and holds a 5-bit pointer to the status bit of that first error. Once a header is captured, the log is frozen. It is released only after software has cleared every reported uncorrectable status bit.

Software clears status bits by writing ones. It then reads the status again to confirm that the log has rearmed. The pointer normally names the first error reported. A later fatal error replaces a pointer that names a non-fatal one. The header log, the pointer and the status survive a warm reset. Only a cold, power-on reset clears them.

Top module: `uncorr_hdr_logger`

## Requirements
- R1: While `coldRstN` is low at a clock edge, all four log words, the pointer and the status are cleared to zero.
- R2: The status is write-one-to-clear. A bit in `errSet` sets its status bit. When `clrValid` is high, a 1 in `clrMask` clears that bit. A set and a clear of the same bit in one cycle leave the bit set. The new status is visible one cycle later.
- R3: While the log is unlocked, a cycle with `errSaveHdr` high and at least one bit of `errSet` set loads the header into the log and locks it. The words are visible one cycle later.
- R4: While the log is locked, no error and no header input changes the log words.
- R5: In the cycle after a `clrValid` write, the log and the pointer rearm if the status is all zero. An error that arrives in the same cycle as the clear keeps the log locked. In the rearm cycle itself, a new header-saving error is captured.
- R6: Header byte k is taken from `hdrIn[8k+7:8k]`. Byte 4w lands in bits 31:24 of log word w, byte 4w+1 in bits 23:16, byte 4w+2 in bits 15:8 and byte 4w+3 in bits 7:0.
- R7: When `hdr16` is 0 (12-byte header), a capture writes words 0 to 2 and leaves word 3 unchanged.
- R8: If no pointer is held, the first cycle with any error loads the pointer with the lowest set bit position of `errSet`, whatever the severities.
- R9: `errFatalMask` bit i = 1 marks status bit i as fatal. If the held pointer names a non-fatal error, a later fatal error moves the pointer to the lowest fatal bit of that cycle. An error of equal severity never moves the pointer.
- R10: While `warmRstN` is low, the log, pointer and status hold and all error and clear inputs are ignored. A warm reset also cancels a rearm check that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Power-on reset, active low, synchronous |
| warmRstN | input | 1 | Warm reset, active low, synchronous |
| errSet | input | 32 | Uncorrectable errors detected this cycle, one bit per status bit |
| errFatalMask | input | 32 | Per-bit severity, 1 = fatal |
| errSaveHdr | input | 1 | The errors of this cycle carry a header to save |
| hdr16 | input | 1 | 1 = 16-byte header, 0 = 12-byte header |
| hdrIn | input | 128 | Header bytes, byte k at bits 8k+7:8k |
| clrValid | input | 1 | Status write strobe |
| clrMask | input | 32 | Write-one-to-clear data |
| errStatus | output | 32 | Uncorrectable error status |
| firstErrPtr | output | 5 | First error pointer |
| hdrLog0 | output | 32 | Header log word 0 |
| hdrLog1 | output | 32 | Header log word 1 |
| hdrLog2 | output | 32 | Header log word 2 |
| hdrLog3 | output | 32 | Header log word 3 |

## Verification
All results are registered. A status change, a header capture and a pointer load all appear one clock after the cycle that carries the error or the write. A rearm takes two clocks: one to register the clear, and one to evaluate the now-empty status. The bench drives inputs on the falling edge and runs a behavioural model on the rising edge. It compares every output on the following falling edge, so each result is checked in the cycle it is due. Directed sequences check the cases that depend on this timing: an error arriving in the same cycle as the clear, a capture made in the rearm cycle, and a warm reset that lands on the cycle of the rearm check.

// File: rtl/uhl_pkg.sv
package uhl_pkg;
  localparam int ERR_BITS  = 32;
  localparam int PTR_BITS  = $clog2(ERR_BITS);
  localparam int HDR_BYTES = 16;
  localparam int WORD_BITS = 32;
  localparam int BYTES_PER_WORD = WORD_BITS / 8;
  localparam int NUM_WORDS = HDR_BYTES / BYTES_PER_WORD;

  typedef struct packed {
    logic                capture;  // load header words
    logic                fullHdr;  // last word also written
    logic                ptrLoad;  // load pointer
    logic [PTR_BITS-1:0] ptrIdx;   // value to load
    logic                rearm;    // log released this cycle
  } ctrl_stb_t;

  function automatic logic [PTR_BITS-1:0] lowestSet(input logic [ERR_BITS-1:0] v);
    logic [PTR_BITS-1:0] idx;
    idx = '0;
    for (int i = ERR_BITS - 1; i >= 0; i--) begin
      if (v[i]) idx = PTR_BITS'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/uhl_ctrl.sv
module uhl_ctrl
  import uhl_pkg::*;
(
  input  logic                clk,
  input  logic                coldRstN,
  input  logic                warmRstN,
  input  logic [ERR_BITS-1:0] errSet,
  input  logic [ERR_BITS-1:0] errFatalMask,
  input  logic                errSaveHdr,
  input  logic                hdr16,
  input  logic                clrValid,
  input  logic [ERR_BITS-1:0] clrMask,
  output logic [ERR_BITS-1:0] errStatus,
  output logic                logLocked,
  output ctrl_stb_t           stb
);
  logic clrPend;   // non-sticky: a clear happened last cycle
  logic ptrValid;
  logic ptrFatal;
  logic rearmNow, effLocked, effValid;
  logic [ERR_BITS-1:0] newErr, fatalNew, clrEff;

  always_comb begin
    rearmNow  = clrPend && (errStatus == '0);
    effLocked = logLocked && !rearmNow;
    effValid  = ptrValid && !rearmNow;
    newErr    = warmRstN ? errSet : '0;
    fatalNew  = newErr & errFatalMask;
    clrEff    = (warmRstN && clrValid) ? clrMask : '0;
    stb         = '0;
    stb.rearm   = warmRstN && rearmNow;
    stb.fullHdr = hdr16;
    if (newErr != '0) begin
      if (!effValid) begin
        stb.ptrLoad = 1'b1;
        stb.ptrIdx  = lowestSet(newErr);
      end else if (!ptrFatal && fatalNew != '0) begin
        stb.ptrLoad = 1'b1;
        stb.ptrIdx  = lowestSet(fatalNew);
      end
    end
    stb.capture = errSaveHdr && (newErr != '0) && !effLocked;
  end

  always_ff @(posedge clk) begin
    if (!coldRstN) begin
      errStatus <= '0;
      logLocked <= 1'b0;
      ptrValid  <= 1'b0;
      ptrFatal  <= 1'b0;
      clrPend   <= 1'b0;
    end else if (!warmRstN) begin
      clrPend <= 1'b0;
    end else begin
      errStatus <= (errStatus & ~clrEff) | newErr;
      clrPend   <= clrValid;
      if (stb.capture)    logLocked <= 1'b1;
      else if (stb.rearm) logLocked <= 1'b0;
      if (stb.ptrLoad) begin
        ptrValid <= 1'b1;
        ptrFatal <= errFatalMask[stb.ptrIdx];
      end else if (stb.rearm) begin
        ptrValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uhl_datapath.sv
module uhl_datapath
  import uhl_pkg::*;
(
  input  logic                                clk,
  input  logic                                coldRstN,
  input  ctrl_stb_t                           stb,
  input  logic [HDR_BYTES*8-1:0]              hdrIn,
  output logic [NUM_WORDS-1:0][WORD_BITS-1:0] hdrWords,
  output logic [PTR_BITS-1:0]                 firstErrPtr
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_BITS-1:0] packed_w;
    logic                 wrEn;
    always_comb begin
      for (int j = 0; j < BYTES_PER_WORD; j++)
        packed_w[WORD_BITS-1-8*j -: 8] = hdrIn[8*(BYTES_PER_WORD*w+j) +: 8];
      wrEn = stb.capture && ((w < NUM_WORDS - 1) || stb.fullHdr);
    end
    always_ff @(posedge clk) begin
      if (!coldRstN)  hdrWords[w] <= '0;
      else if (wrEn)  hdrWords[w] <= packed_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!coldRstN)        firstErrPtr <= '0;
    else if (stb.ptrLoad) firstErrPtr <= stb.ptrIdx;
  end
endmodule

// File: rtl/uncorr_hdr_logger.sv
module uncorr_hdr_logger
  import uhl_pkg::*;
(
  input  logic                   clk,
  input  logic                   coldRstN,
  input  logic                   warmRstN,
  input  logic [ERR_BITS-1:0]    errSet,
  input  logic [ERR_BITS-1:0]    errFatalMask,
  input  logic                   errSaveHdr,
  input  logic                   hdr16,
  input  logic [HDR_BYTES*8-1:0] hdrIn,
  input  logic                   clrValid,
  input  logic [ERR_BITS-1:0]    clrMask,
  output logic [ERR_BITS-1:0]    errStatus,
  output logic [PTR_BITS-1:0]    firstErrPtr,
  output logic [WORD_BITS-1:0]   hdrLog0,
  output logic [WORD_BITS-1:0]   hdrLog1,
  output logic [WORD_BITS-1:0]   hdrLog2,
  output logic [WORD_BITS-1:0]   hdrLog3
);
  ctrl_stb_t ctrlStb;
  logic      logLocked;
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] hdrWords;

  uhl_ctrl u_ctrl (
    .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN),
    .errSet(errSet), .errFatalMask(errFatalMask), .errSaveHdr(errSaveHdr),
    .hdr16(hdr16), .clrValid(clrValid), .clrMask(clrMask),
    .errStatus(errStatus), .logLocked(logLocked), .stb(ctrlStb)
  );

  uhl_datapath u_dp (
    .clk(clk), .coldRstN(coldRstN), .stb(ctrlStb), .hdrIn(hdrIn),
    .hdrWords(hdrWords), .firstErrPtr(firstErrPtr)
  );

  assign hdrLog0 = hdrWords[0];
  assign hdrLog1 = hdrWords[1];
  assign hdrLog2 = hdrWords[2];
  assign hdrLog3 = hdrWords[3];
endmodule

// File: rtl/uhl_checker.sv
module uhl_checker
  import uhl_pkg::*;
(
  input logic                 clk,
  input logic                 coldRstN,
  input logic                 warmRstN,
  input logic [ERR_BITS-1:0]  errSet,
  input logic [ERR_BITS-1:0]  errStatus,
  input logic [PTR_BITS-1:0]  firstErrPtr,
  input logic [WORD_BITS-1:0] hdrLog0,
  input logic [WORD_BITS-1:0] hdrLog1,
  input logic [WORD_BITS-1:0] hdrLog2,
  input logic [WORD_BITS-1:0] hdrLog3,
  input logic                 logLocked,
  input ctrl_stb_t            ctrlStb
);
  AST_STATUS_SETS: assert property (@(posedge clk) disable iff (!coldRstN)
    (warmRstN && errSet != '0) |=> ((errStatus & $past(errSet)) == $past(errSet))); // R2

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!coldRstN)
    (logLocked && !ctrlStb.rearm) |=>
      ($stable(hdrLog0) && $stable(hdrLog1) && $stable(hdrLog2) && $stable(hdrLog3))); // R4

  AST_UNLOCK_EMPTY: assert property (@(posedge clk) disable iff (!coldRstN)
    ($fell(logLocked) && $past(coldRstN)) |-> ($past(errStatus) == '0)); // R5

  AST_SHORT_HDR_W3: assert property (@(posedge clk) disable iff (!coldRstN)
    (ctrlStb.capture && !ctrlStb.fullHdr) |=> $stable(hdrLog3)); // R7

  AST_PTR_NEEDS_ERR: assert property (@(posedge clk) disable iff (!coldRstN)
    (!$stable(firstErrPtr) && $past(coldRstN)) |-> ($past(errSet) != '0 && $past(warmRstN))); // R8

  AST_WARM_STICKY: assert property (@(posedge clk) disable iff (!coldRstN)
    !warmRstN |=> ($stable(errStatus) && $stable(firstErrPtr) && $stable(hdrLog0) &&
                   $stable(hdrLog1) && $stable(hdrLog2) && $stable(hdrLog3))); // R10
endmodule

bind uncorr_hdr_logger uhl_checker u_chk (
  .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN), .errSet(errSet),
  .errStatus(errStatus), .firstErrPtr(firstErrPtr),
  .hdrLog0(hdrLog0), .hdrLog1(hdrLog1), .hdrLog2(hdrLog2), .hdrLog3(hdrLog3),
  .logLocked(logLocked), .ctrlStb(ctrlStb)
);

// File: tb/tb_uncorr_hdr_logger.sv
module tb_uncorr_hdr_logger;
  logic clk = 1'b0;
  logic coldRstN, warmRstN, errSaveHdr, hdr16, clrValid;
  logic [31:0] errSet, errFatalMask, clrMask;
  logic [127:0] hdrIn;
  logic [31:0] errStatus, hdrLog0, hdrLog1, hdrLog2, hdrLog3;
  logic [4:0] firstErrPtr;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit cmpOn   = 1'b0;

  // behavioural reference state
  logic [31:0] mStatus, mLog [4];
  logic [4:0]  mPtr;
  bit mLocked, mPend, mPv, mPf;

  uncorr_hdr_logger dut (
    .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN), .errSet(errSet),
    .errFatalMask(errFatalMask), .errSaveHdr(errSaveHdr), .hdr16(hdr16),
    .hdrIn(hdrIn), .clrValid(clrValid), .clrMask(clrMask),
    .errStatus(errStatus), .firstErrPtr(firstErrPtr),
    .hdrLog0(hdrLog0), .hdrLog1(hdrLog1), .hdrLog2(hdrLog2), .hdrLog3(hdrLog3)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lowBit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [127:0] mkHdr(input logic [7:0] base);
    logic [127:0] h;
    for (int k = 0; k < 16; k++) h[8*k +: 8] = base + 8'(k);
    return h;
  endfunction

  // reference model
  always @(posedge clk) begin
    if (!coldRstN) begin
      mStatus = '0; mPtr = '0; mLocked = 0; mPend = 0; mPv = 0; mPf = 0;
      for (int w = 0; w < 4; w++) mLog[w] = '0;
    end else if (!warmRstN) begin
      mPend = 0;
    end else begin
      bit rearm, lk;
      rearm = mPend && (mStatus == 0);
      lk = mLocked && !rearm;
      if (rearm) mPv = 0;
      if (errSet != 0) begin
        if (!mPv) begin
          mPtr = 5'(lowBit(errSet)); mPf = errFatalMask[mPtr]; mPv = 1;
        end else if (!mPf && (errSet & errFatalMask) != 0) begin
          mPtr = 5'(lowBit(errSet & errFatalMask)); mPf = 1;
        end
      end
      if (errSaveHdr && errSet != 0 && !lk) begin
        for (int w = 0; w < (hdr16 ? 4 : 3); w++)
          mLog[w] = {hdrIn[8*(4*w)+:8], hdrIn[8*(4*w+1)+:8],
                     hdrIn[8*(4*w+2)+:8], hdrIn[8*(4*w+3)+:8]};
        lk = 1;
      end
      mLocked = lk;
      mStatus = (mStatus & ~(clrValid ? clrMask : 32'h0)) | errSet;
      mPend = clrValid;
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      check("R2", "model status", errStatus, mStatus);
      check("R8", "model pointer", {27'h0, firstErrPtr}, {27'h0, mPtr});
      check("R4", "model log0", hdrLog0, mLog[0]);
      check("R4", "model log1", hdrLog1, mLog[1]);
      check("R4", "model log2", hdrLog2, mLog[2]);
      check("R7", "model log3", hdrLog3, mLog[3]);
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic quiet();
    errSet = '0; errSaveHdr = 0; clrValid = 0; clrMask = '0;
  endtask

  task automatic inject(input logic [31:0] e, input bit save, input bit full,
                        input logic [7:0] base);
    errSet = e; errSaveHdr = save; hdr16 = full; hdrIn = mkHdr(base);
  endtask

  initial begin
    coldRstN = 0; warmRstN = 1; hdr16 = 1; hdrIn = '0;
    errFatalMask = 32'h0000_0022;   // bits 1 and 5 fatal
    quiet();
    cyc(); cyc();
    coldRstN = 1; cmpOn = 1;
    check("R1", "status after cold", errStatus, 32'h0);
    check("R1", "log0 after cold", hdrLog0, 32'h0);
    check("R1", "ptr after cold", {27'h0, firstErrPtr}, 32'h0);

    inject(32'h8, 1, 1, 8'h10); cyc(); quiet();
    check("R6", "log0 byte order", hdrLog0, 32'h10111213);
    check("R3", "log3 captured", hdrLog3, 32'h1C1D1E1F);
    check("R8", "first pointer", {27'h0, firstErrPtr}, 32'd3);
    check("R2", "status set", errStatus, 32'h8);

    inject(32'h20, 1, 1, 8'hA0); cyc(); quiet();
    check("R4", "locked log0", hdrLog0, 32'h10111213);
    check("R9", "fatal override", {27'h0, firstErrPtr}, 32'd5);

    inject(32'h2, 0, 1, 8'h00); cyc(); quiet();
    check("R9", "equal severity holds", {27'h0, firstErrPtr}, 32'd5);

    clrValid = 1; clrMask = '1; errSet = 32'h80; cyc(); quiet();
    check("R2", "set beats clear", errStatus, 32'h80);
    inject(32'h1, 1, 1, 8'hA0); cyc(); quiet();
    check("R5", "still locked", hdrLog0, 32'h10111213);

    clrValid = 1; clrMask = '1; cyc(); quiet();
    check("R2", "cleared", errStatus, 32'h0);
    inject(32'h4, 1, 0, 8'h40); cyc(); quiet();
    check("R5", "capture in rearm cycle", hdrLog0, 32'h40414243);
    check("R6", "log2 order", hdrLog2, 32'h48494A4B);
    check("R7", "short hdr word3", hdrLog3, 32'h1C1D1E1F);
    check("R8", "pointer after rearm", {27'h0, firstErrPtr}, 32'd2);

    clrValid = 1; clrMask = '1; cyc(); quiet(); cyc();
    inject(32'h210, 0, 1, 8'h00); cyc(); quiet();
    check("R8", "simultaneous lowest", {27'h0, firstErrPtr}, 32'd4);

    warmRstN = 0; inject(32'h40, 1, 1, 8'h55); clrValid = 1; clrMask = '1;
    cyc(); cyc(); quiet(); warmRstN = 1;
    check("R10", "status held in warm", errStatus, 32'h210);
    check("R10", "ptr held in warm", {27'h0, firstErrPtr}, 32'd4);
    check("R10", "log held in warm", hdrLog0, 32'h40414243);

    inject(32'h100, 1, 1, 8'h60); cyc(); quiet();
    check("R3", "second capture", hdrLog0, 32'h60616263);
    clrValid = 1; clrMask = '1; cyc(); quiet();
    warmRstN = 0; cyc(); warmRstN = 1;
    inject(32'h8, 1, 1, 8'h80); cyc(); quiet();
    check("R10", "warm cancels rearm", hdrLog0, 32'h60616263);
    check("R9", "nonfatal keeps ptr", {27'h0, firstErrPtr}, 32'd4);

    // random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      errSet = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
      errFatalMask = $urandom;
      errSaveHdr = $urandom % 2;
      hdr16 = $urandom % 2;
      hdrIn = {$urandom, $urandom, $urandom, $urandom};
      clrValid = ($urandom % 5 == 0);
      clrMask = ($urandom % 2) ? '1 : $urandom;
      warmRstN = ($urandom % 40 != 0);
      cyc();
    end
    quiet(); warmRstN = 1;

    coldRstN = 0; cyc(); coldRstN = 1;
    check("R1", "status after 2nd cold", errStatus, 32'h0);
    check("R1", "log1 after 2nd cold", hdrLog1, 32'h0);
    check("R1", "log3 after 2nd cold", hdrLog3, 32'h0);

    cmpOn = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule